// File: doc/BRIEF.md
# Mixed-Radix Delay Step Counter

This block keeps the receive-enable delay of one byte lane as a position in a mixed-radix number space. The least significant digit is a fine tap that runs from 0 to 14, which is fifteen settings and not a power of two. Above it sits a four-step medium digit, and above that a sixteen-step coarse digit. A separate phase-interpolator value sits beside these three digits and takes no part in carries or borrows.

A training sequencer, which lives outside this block, moves the delay one medium step or one tap step at a time. Each move is a one-cycle request. The block does the carry or borrow between digits. When a move would go past the lowest or highest position, the block refuses it: it raises a one-cycle error pulse and leaves the position exactly as it was. The sequencer can also load a complete starting position in one cycle, and it can overwrite the interpolator value at any time.

The block presents each digit on its own output. It also presents a packed control byte that the delay line consumes. In that byte the tap value sits in the low nibble, the interpolator value in bits 6:4, and bit 7 is a pass-through that the block does not modify.

Top module: `dly_step_ctr`

## Requirements
- R1: A synchronous active-high reset sets coarse, medium, tap and interpolator to zero and clears the error pulse. When no command is given in a cycle, the position stays unchanged and the error output stays low.
- R2: When load is asserted, the next clock edge sets coarse, medium, tap and interpolator to the load inputs. Load takes priority over every step request given in the same cycle, and over an interpolator write given in the same cycle.
- R3: Medium-up adds one to medium. At medium 3 it sets medium to 0 and adds one to coarse. At coarse 15 with medium 3 it fails. In every case tap stays unchanged.
- R4: Medium-down subtracts one from medium. At medium 0 it sets medium to 3 and subtracts one from coarse. At coarse 0 with medium 0 it fails. In every case tap stays unchanged.
- R5: Tap-up adds one to tap. At tap 14 it sets tap to 0 and performs a medium-up. If that medium-up would fail, the whole tap step fails.
- R6: Tap-down subtracts one from tap. At tap 0 it sets tap to 14 and performs a medium-down. If that medium-down would fail, the whole tap step fails.
- R7: A failed step raises step_err for exactly the cycle after the request and leaves coarse, medium and tap unchanged. step_err is high only after a failed step request.
- R8: At most one step is accepted per cycle, chosen in this order: medium-up first, then medium-down, then tap-up, then tap-down. The other requests in that cycle are ignored.
- R9: An interpolator write without load replaces the interpolator value at the next edge. It does not block a step that is accepted in the same cycle.
- R10: dly_ctl[3:0] equals tap, dly_ctl[6:4] equals the interpolator value, and dly_ctl[7] equals the ctl_msb_keep input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Load a full position this cycle |
| load_crs | input | 4 | Coarse value to load |
| load_med | input | 2 | Medium value to load |
| load_tap | input | 4 | Tap value to load |
| load_pi | input | 3 | Interpolator value to load |
| pi_wr | input | 1 | Write the interpolator value |
| pi_val | input | 3 | Interpolator value to write |
| med_up | input | 1 | Request a medium step up |
| med_dn | input | 1 | Request a medium step down |
| tap_up | input | 1 | Request a tap step up |
| tap_dn | input | 1 | Request a tap step down |
| ctl_msb_keep | input | 1 | Value passed to bit 7 of dly_ctl |
| crs | output | 4 | Current coarse value |
| med | output | 2 | Current medium value |
| tap | output | 4 | Current tap value |
| pi | output | 3 | Current interpolator value |
| dly_ctl | output | 8 | Packed delay control byte |
| step_err | output | 1 | One-cycle pulse after a refused step |

## Verification
The bench builds the block with its default limits: coarse last value 15, medium last value 3 and tap last value 14. With these limits the whole space is only 960 positions. That small size lets the bench load every legal position and apply each of the four step requests from it. The expected result comes from a single linear index, so every carry, every borrow and both saturation ends are covered. Directed cycles then cover simultaneous requests, load priority, interpolator writes and the packed byte.

// File: rtl/dly_step_pkg.sv
package dly_step_pkg;

    localparam int CRS_W = 4;
    localparam int MED_W = 2;
    localparam int TAP_W = 4;
    localparam int PI_W  = 3;
    localparam int CTL_W = 1 + PI_W + TAP_W;

    typedef struct packed {
        logic [CRS_W-1:0] crs;
        logic [MED_W-1:0] med;
        logic [TAP_W-1:0] tap;
    } dly_pos_t;

    typedef struct packed {
        logic     ok;
        dly_pos_t pos;
    } step_res_t;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_MED_UP = 3'd1,
        OP_MED_DN = 3'd2,
        OP_TAP_UP = 3'd3,
        OP_TAP_DN = 3'd4
    } step_op_t;

    function automatic logic [CTL_W-1:0] pack_ctl(
        input logic             keep,
        input logic [PI_W-1:0]  piv,
        input logic [TAP_W-1:0] tapv
    );
        return {keep, piv, tapv};
    endfunction

endpackage

// File: rtl/dly_cmd_arb.sv
module dly_cmd_arb
    import dly_step_pkg::*;
(
    input  logic     med_up,
    input  logic     med_dn,
    input  logic     tap_up,
    input  logic     tap_dn,
    output step_op_t op
);
    always_comb begin
        if (med_up)      op = OP_MED_UP;
        else if (med_dn) op = OP_MED_DN;
        else if (tap_up) op = OP_TAP_UP;
        else if (tap_dn) op = OP_TAP_DN;
        else             op = OP_NONE;
    end
endmodule

// File: rtl/dly_med_step.sv
module dly_med_step
    import dly_step_pkg::*;
#(
    parameter int CRS_LAST = 15,
    parameter int MED_LAST = 3
) (
    input  dly_pos_t  pos_i,
    input  logic      dir_up,
    output step_res_t res_o
);
    localparam logic [CRS_W-1:0] CRS_TOP = CRS_W'(CRS_LAST);
    localparam logic [MED_W-1:0] MED_TOP = MED_W'(MED_LAST);

    always_comb begin
        res_o.ok  = 1'b1;
        res_o.pos = pos_i;
        if (dir_up) begin
            if (pos_i.med != MED_TOP) begin
                res_o.pos.med = pos_i.med + MED_W'(1);
            end else if (pos_i.crs != CRS_TOP) begin
                res_o.pos.med = '0;
                res_o.pos.crs = pos_i.crs + CRS_W'(1);
            end else begin
                res_o.ok = 1'b0;
            end
        end else begin
            if (pos_i.med != '0) begin
                res_o.pos.med = pos_i.med - MED_W'(1);
            end else if (pos_i.crs != '0) begin
                res_o.pos.med = MED_TOP;
                res_o.pos.crs = pos_i.crs - CRS_W'(1);
            end else begin
                res_o.ok = 1'b0;
            end
        end
    end
endmodule

// File: rtl/dly_tap_step.sv
module dly_tap_step
    import dly_step_pkg::*;
#(
    parameter int CRS_LAST = 15,
    parameter int MED_LAST = 3,
    parameter int TAP_LAST = 14
) (
    input  dly_pos_t  pos_i,
    input  logic      dir_up,
    output step_res_t res_o
);
    localparam logic [TAP_W-1:0] TAP_TOP = TAP_W'(TAP_LAST);

    step_res_t carry_res;

    dly_med_step #(
        .CRS_LAST(CRS_LAST),
        .MED_LAST(MED_LAST)
    ) u_carry (
        .pos_i (pos_i),
        .dir_up(dir_up),
        .res_o (carry_res)
    );

    always_comb begin
        res_o.ok  = 1'b1;
        res_o.pos = pos_i;
        if (dir_up) begin
            if (pos_i.tap != TAP_TOP) begin
                res_o.pos.tap = pos_i.tap + TAP_W'(1);
            end else if (carry_res.ok) begin
                res_o.pos     = carry_res.pos;
                res_o.pos.tap = '0;
            end else begin
                res_o.ok = 1'b0;
            end
        end else begin
            if (pos_i.tap != '0) begin
                res_o.pos.tap = pos_i.tap - TAP_W'(1);
            end else if (carry_res.ok) begin
                res_o.pos     = carry_res.pos;
                res_o.pos.tap = TAP_TOP;
            end else begin
                res_o.ok = 1'b0;
            end
        end
    end
endmodule

// File: rtl/dly_step_ctr.sv
module dly_step_ctr
    import dly_step_pkg::*;
#(
    parameter int CRS_LAST = 15,
    parameter int MED_LAST = 3,
    parameter int TAP_LAST = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [CRS_W-1:0] load_crs,
    input  logic [MED_W-1:0] load_med,
    input  logic [TAP_W-1:0] load_tap,
    input  logic [PI_W-1:0]  load_pi,
    input  logic             pi_wr,
    input  logic [PI_W-1:0]  pi_val,
    input  logic             med_up,
    input  logic             med_dn,
    input  logic             tap_up,
    input  logic             tap_dn,
    input  logic             ctl_msb_keep,
    output logic [CRS_W-1:0] crs,
    output logic [MED_W-1:0] med,
    output logic [TAP_W-1:0] tap,
    output logic [PI_W-1:0]  pi,
    output logic [CTL_W-1:0] dly_ctl,
    output logic             step_err
);
    dly_pos_t  pos_q;
    logic [PI_W-1:0] pi_q;
    logic      err_q;
    step_op_t  op;
    step_res_t med_res;
    step_res_t tap_res;
    step_res_t sel_res;

    dly_cmd_arb u_arb (
        .med_up(med_up),
        .med_dn(med_dn),
        .tap_up(tap_up),
        .tap_dn(tap_dn),
        .op    (op)
    );

    dly_med_step #(
        .CRS_LAST(CRS_LAST),
        .MED_LAST(MED_LAST)
    ) u_med (
        .pos_i (pos_q),
        .dir_up(op == OP_MED_UP),
        .res_o (med_res)
    );

    dly_tap_step #(
        .CRS_LAST(CRS_LAST),
        .MED_LAST(MED_LAST),
        .TAP_LAST(TAP_LAST)
    ) u_tap (
        .pos_i (pos_q),
        .dir_up(op == OP_TAP_UP),
        .res_o (tap_res)
    );

    always_comb begin
        unique case (op)
            OP_MED_UP, OP_MED_DN: sel_res = med_res;
            OP_TAP_UP, OP_TAP_DN: sel_res = tap_res;
            default: begin
                sel_res.ok  = 1'b1;
                sel_res.pos = pos_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            pi_q  <= '0;
            err_q <= 1'b0;
        end else if (load_en) begin
            pos_q.crs <= load_crs;
            pos_q.med <= load_med;
            pos_q.tap <= load_tap;
            pi_q      <= load_pi;
            err_q     <= 1'b0;
        end else begin
            if (sel_res.ok) pos_q <= sel_res.pos;
            err_q <= (op != OP_NONE) && !sel_res.ok;
            if (pi_wr) pi_q <= pi_val;
        end
    end

    assign crs      = pos_q.crs;
    assign med      = pos_q.med;
    assign tap      = pos_q.tap;
    assign pi       = pi_q;
    assign step_err = err_q;
    assign dly_ctl  = pack_ctl(ctl_msb_keep, pi_q, pos_q.tap);

endmodule

// File: rtl/dly_step_chk.sv
module dly_step_chk
    import dly_step_pkg::*;
#(
    parameter int MED_LAST = 3,
    parameter int TAP_LAST = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             load_en,
    input logic [CRS_W-1:0] load_crs,
    input logic [MED_W-1:0] load_med,
    input logic [TAP_W-1:0] load_tap,
    input logic [PI_W-1:0]  load_pi,
    input logic             med_up,
    input logic             med_dn,
    input logic             tap_up,
    input logic             tap_dn,
    input logic [CRS_W-1:0] crs,
    input logic [MED_W-1:0] med,
    input logic [TAP_W-1:0] tap,
    input logic [PI_W-1:0]  pi,
    input logic             step_err
);
    logic any_step;
    assign any_step = med_up | med_dn | tap_up | tap_dn;

    // R7: refused step leaves the position untouched
    a_r7_fail_holds: assert property (@(posedge clk) disable iff (rst)
        step_err |-> ($stable(crs) && $stable(med) && $stable(tap)));

    // R7: error only follows a step request without load
    a_r7_err_cause: assert property (@(posedge clk) disable iff (rst)
        step_err |-> ($past(any_step) && !$past(load_en)));

    // R2: load lands on the next edge
    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(load_en)) |->
        (crs == $past(load_crs) && med == $past(load_med) &&
         tap == $past(load_tap) && pi == $past(load_pi)));

    // R1: idle cycles keep the position and raise no error
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load_en) && !$past(any_step)) |->
        ($stable(crs) && $stable(med) && $stable(tap) && !step_err));

    // R5: tap-up below the wrap point moves only the tap
    a_r5_tap_inc: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tap_up && !med_up && !med_dn && !load_en &&
                              tap != TAP_W'(TAP_LAST))) |->
        (tap == $past(tap) + TAP_W'(1) && $stable(med) && $stable(crs)));

    // R3: medium-up below the wrap point moves only the medium digit
    a_r3_med_inc: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(med_up && !load_en && med != MED_W'(MED_LAST))) |->
        (med == $past(med) + MED_W'(1) && $stable(tap) && $stable(crs)));
endmodule

bind dly_step_ctr dly_step_chk #(
    .MED_LAST(MED_LAST),
    .TAP_LAST(TAP_LAST)
) u_dly_step_chk (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .load_crs(load_crs),
    .load_med(load_med),
    .load_tap(load_tap),
    .load_pi (load_pi),
    .med_up  (med_up),
    .med_dn  (med_dn),
    .tap_up  (tap_up),
    .tap_dn  (tap_dn),
    .crs     (crs),
    .med     (med),
    .tap     (tap),
    .pi      (pi),
    .step_err(step_err)
);

// File: tb/tb_dly_step_ctr.sv
`timescale 1ns/1ps
module tb_dly_step_ctr;
    logic       clk = 1'b0;
    logic       rst;
    logic       load_en;
    logic [3:0] load_crs;
    logic [1:0] load_med;
    logic [3:0] load_tap;
    logic [2:0] load_pi;
    logic       pi_wr;
    logic [2:0] pi_val;
    logic       med_up, med_dn, tap_up, tap_dn;
    logic       ctl_msb_keep;
    logic [3:0] crs;
    logic [1:0] med;
    logic [3:0] tap;
    logic [2:0] pi;
    logic [7:0] dly_ctl;
    logic       step_err;

    int checks = 0;
    int errors = 0;

    localparam int NMED = 4;
    localparam int NTAP = 15;
    localparam int NPOS = 16 * NMED * NTAP;

    always #2.5 clk = ~clk;

    dly_step_ctr dut (
        .clk(clk), .rst(rst), .load_en(load_en), .load_crs(load_crs),
        .load_med(load_med), .load_tap(load_tap), .load_pi(load_pi),
        .pi_wr(pi_wr), .pi_val(pi_val), .med_up(med_up), .med_dn(med_dn),
        .tap_up(tap_up), .tap_dn(tap_dn), .ctl_msb_keep(ctl_msb_keep),
        .crs(crs), .med(med), .tap(tap), .pi(pi), .dly_ctl(dly_ctl),
        .step_err(step_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        load_en = 0; pi_wr = 0;
        med_up = 0; med_dn = 0; tap_up = 0; tap_dn = 0;
    endtask

    task automatic load(input int c, input int m, input int t, input int p);
        load_en = 1; load_crs = 4'(c); load_med = 2'(m);
        load_tap = 4'(t); load_pi = 3'(p);
        tick();
        idle();
    endtask

    function automatic int pos_idx();
        return (int'(crs) * NMED + int'(med)) * NTAP + int'(tap);
    endfunction

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; ctl_msb_keep = 0;
        load_crs = 0; load_med = 0; load_tap = 0; load_pi = 0; pi_val = 0;
        idle();
        @(negedge clk);
        load_en = 1; load_crs = 4'd9; load_pi = 3'd5;
        tick();
        tick();
        idle();
        chk("R1 reset position", pos_idx(), 0);
        chk("R1 reset pi", int'(pi), 0);
        chk("R1 reset err", int'(step_err), 0);
        rst = 0;
        tick();
        chk("R1 idle hold", pos_idx(), 0);

        // Sweep: every legal position, every step kind
        for (int c = 0; c < 16; c++) begin
            for (int m = 0; m < NMED; m++) begin
                for (int t = 0; t < NTAP; t++) begin
                    for (int k = 0; k < 4; k++) begin
                        int start;
                        int exp_idx;
                        int exp_err;
                        string tag;
                        start = (c * NMED + m) * NTAP + t;
                        load(c, m, t, (c + t) % 8);
                        if (k == 0) chk("R2 load", pos_idx(), start);
                        exp_err = 0;
                        exp_idx = start;
                        case (k)
                            0: begin
                                tag = "R3 med up"; med_up = 1;
                                if (c * NMED + m == 16 * NMED - 1) exp_err = 1;
                                else exp_idx = start + NTAP;
                            end
                            1: begin
                                tag = "R4 med down"; med_dn = 1;
                                if (c * NMED + m == 0) exp_err = 1;
                                else exp_idx = start - NTAP;
                            end
                            2: begin
                                tag = "R5 tap up"; tap_up = 1;
                                if (start == NPOS - 1) exp_err = 1;
                                else exp_idx = start + 1;
                            end
                            default: begin
                                tag = "R6 tap down"; tap_dn = 1;
                                if (start == 0) exp_err = 1;
                                else exp_idx = start - 1;
                            end
                        endcase
                        tick();
                        idle();
                        chk(tag, pos_idx(), exp_idx);
                        chk(exp_err ? "R7 err raised" : "R7 no err", int'(step_err), exp_err);
                        if (exp_err == 1) begin
                            tick();
                            chk("R7 err one cycle", int'(step_err), 0);
                            chk("R7 hold after fail", pos_idx(), start);
                        end
                    end
                end
            end
        end

        // R8: simultaneous requests
        load(5, 2, 7, 0);
        med_up = 1; med_dn = 1; tap_up = 1; tap_dn = 1;
        tick(); idle();
        chk("R8 all four -> med up", pos_idx(), (5 * NMED + 3) * NTAP + 7);
        load(5, 2, 7, 0);
        med_dn = 1; tap_up = 1; tap_dn = 1;
        tick(); idle();
        chk("R8 med down wins", pos_idx(), (5 * NMED + 1) * NTAP + 7);
        load(5, 2, 7, 0);
        tap_up = 1; tap_dn = 1;
        tick(); idle();
        chk("R8 tap up wins", pos_idx(), (5 * NMED + 2) * NTAP + 8);

        // R2: load beats steps and pi write
        load(3, 1, 4, 2);
        load_en = 1; load_crs = 4'd7; load_med = 2'd0; load_tap = 4'd11; load_pi = 3'd6;
        med_up = 1; tap_dn = 1; pi_wr = 1; pi_val = 3'd1;
        tick(); idle();
        chk("R2 load over steps", pos_idx(), (7 * NMED + 0) * NTAP + 11);
        chk("R2 load over pi write", int'(pi), 6);
        chk("R2 load clears err", int'(step_err), 0);

        // R9: pi write alongside a step
        pi_wr = 1; pi_val = 3'd3; tap_up = 1;
        tick(); idle();
        chk("R9 pi written", int'(pi), 3);
        chk("R9 step also taken", pos_idx(), (7 * NMED + 0) * NTAP + 12);

        // R10: packed byte
        ctl_msb_keep = 1;
        #0.5;
        chk("R10 byte keep=1", int'(dly_ctl), 128 + 3 * 16 + 12);
        ctl_msb_keep = 0;
        #0.5;
        chk("R10 byte keep=0", int'(dly_ctl), 3 * 16 + 12);
        load(15, 3, 14, 7);
        chk("R10 byte at top", int'(dly_ctl), 7 * 16 + 14);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule